// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is an I2C slave that lets a host processor read and write a small on-chip register file. A fast system clock oversamples the SCL and SDA lines. The block detects START, repeated START and STOP, and it decodes address, register-pointer and data bytes with the most significant bit first. It acknowledges a byte by holding SDA low for the ninth clock pulse. It never drives SDA high: the output is an open-drain enable that pulls the line low. The block never stretches the clock, so it follows any host SCL rate that is slow enough for the oversampling.

The 7-bit device address has two parts. The upper five bits come from a base-address register at location 0, which resets to 0x4A. The lower two bits come straight from two select pins. A change on the pins takes effect on the next address phase, and no reset is needed. The host can rewrite the base register over the bus, which lets more than four such devices share one bus. Bit 0 of location 1 selects the write mode:
- Mode 0 (page mode): a register pointer follows the address byte, and the data bytes go to successive locations.
- Mode 1 (repeat mode): register addresses and data bytes alternate, with no auto-increment.

Reads always auto-increment for as long as the host acknowledges.

Top module: `i2c_regif_slave`

## Requirements
- R1: After reset the SDA pull-down is off and the base address is 7'h4A, so with select pins 2'b10 the device answers address 7'h4A.
- R2: The device acknowledges only the address {base[6:2], addr_sel[1:0]}. A pin change between transactions takes effect without a reset.
- R3: After a non-matching address the slave gives no acknowledge and stores nothing until the next START.
- R4: Every address byte that matches, every register-pointer byte and every data byte is acknowledged by SDA held low for the ninth SCL pulse.
- R5: With location 1 bit 0 = 0, a write is address+W, a pointer byte, then data bytes. Each data byte is stored at the pointer, and the pointer then increments.
- R6: With location 1 bit 0 = 1, a write after address+W is a series of pointer/data pairs. Each data byte goes to the pointer received just before it, with no increment. Location 1 keeps only bit 0.
- R7: A read is address+W, a pointer byte, then a repeated START and address+R. The slave sends the byte at the pointer. After a master ACK the pointer increments and the next byte follows. After a NAK the slave releases SDA.
- R8: There are 16 locations, at indices 0 to 15. A read of any pointer from 16 to 255 returns 8'h00, and a write there is acknowledged but has no effect. Location 0 reads back {1'b0, base}.
- R9: A write to location 0 changes the base address, and later transactions must use the new base combined with the pins.
- R10: A START or STOP in the middle of a byte aborts the transfer and stores nothing. A START re-enters address matching at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (the wired-AND bus value) |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_sel | input | 2 | Live select pins for the two low address bits |

## Verification
The bench uses the default parameters: 16 locations, two synchronizer stages, two select pins and a reset base of 0x4A. It drives SCL with a quarter period of eight system clocks. With these sizes the bench can do the following:
- Sweep all four pin codes against all four neighbouring device addresses.
- Write every implemented location in one page burst.
- Read the whole file back, running past the end into the unimplemented space.

The bench keeps a masked shadow model of the file. From that model it also checks repeat-mode pairs, aborts in the middle of a byte, and moving the device by rewriting its base.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_TXLOAD
    } st_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_SLV,
        K_REG,
        K_DAT
    } kind_e;
endpackage

// File: rtl/i2c_line_front.sv
module i2c_line_front #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sy;
        logic [STAGES-1:0] sda_sy;
        logic              scl_p;
        logic              sda_p;
    } fe_t;

    fe_t fe_d, fe_q;

    always_comb begin
        fe_d        = fe_q;
        fe_d.scl_sy = {fe_q.scl_sy[STAGES-2:0], scl_i};
        fe_d.sda_sy = {fe_q.sda_sy[STAGES-2:0], sda_i};
        fe_d.scl_p  = fe_q.scl_sy[STAGES-1];
        fe_d.sda_p  = fe_q.sda_sy[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= '1;
        else        fe_q <= fe_d;
    end

    assign scl_s     = fe_q.scl_sy[STAGES-1];
    assign sda_s     = fe_q.sda_sy[STAGES-1];
    assign scl_rise  = scl_s & ~fe_q.scl_p;
    assign scl_fall  = ~scl_s & fe_q.scl_p;
    assign start_det = scl_s & fe_q.scl_p & fe_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & fe_q.scl_p & ~fe_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    parameter int BASE_RST = 'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-2:0] base,
    output logic              mode
);
    localparam int SA_W  = DATA_W - 1;
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS*DATA_W-1:0] flat;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        localparam logic [DATA_W-1:0] MASK =
            (i == 0) ? DATA_W'((1 << SA_W) - 1) :
            (i == 1) ? DATA_W'(1) : {DATA_W{1'b1}};
        localparam logic [DATA_W-1:0] RSTV = (i == 0) ? DATA_W'(BASE_RST) : '0;

        logic [DATA_W-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (we && waddr == DATA_W'(i)) cell_d = wdata & MASK;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= RSTV;
            else        cell_q <= cell_d;
        end

        assign flat[i*DATA_W +: DATA_W] = cell_q;
    end

    always_comb begin
        if (int'(raddr) < NUM_REGS) rdata = flat[raddr[IDX_W-1:0]*DATA_W +: DATA_W];
        else                        rdata = '0;
    end

    assign base = flat[SA_W-1:0];
    assign mode = flat[DATA_W];
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
    import i2c_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PIN_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic [DATA_W-2:PIN_W]   base_hi,
    input  logic [PIN_W-1:0]        pins,
    input  logic                    mode,
    input  logic [DATA_W-1:0]       rdata,
    output logic                    sda_oe,
    output logic                    we,
    output logic [DATA_W-1:0]       waddr,
    output logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       raddr
);
    localparam int SA_W  = DATA_W - 1;
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic              rw;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] ptr;
        logic              oe;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [SA_W-1:0] eff_addr;

    assign eff_addr = {base_hi, pins};

    always_comb begin
        s_d   = s_q;
        we    = 1'b0;
        waddr = s_q.ptr;
        wdata = s_q.sh;
        if (start_det) begin
            s_d.st   = ST_RX;
            s_d.kind = K_SLV;
            s_d.cnt  = '0;
            s_d.oe   = 1'b0;
        end else if (stop_det) begin
            s_d.st = ST_IDLE;
            s_d.oe = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_RX: begin
                    if (scl_rise && s_q.cnt != CNT_W'(DATA_W)) begin
                        s_d.sh  = {s_q.sh[DATA_W-2:0], sda_s};
                        s_d.cnt = s_q.cnt + 1'b1;
                    end else if (scl_fall && s_q.cnt == CNT_W'(DATA_W)) begin
                        unique case (s_q.kind)
                            K_SLV: begin
                                if (s_q.sh[DATA_W-1:1] == eff_addr) begin
                                    s_d.oe   = 1'b1;
                                    s_d.rw   = s_q.sh[0];
                                    s_d.kind = K_REG;
                                    s_d.st   = ST_ACK;
                                end else begin
                                    s_d.st = ST_IDLE;
                                end
                            end
                            K_REG: begin
                                s_d.ptr  = s_q.sh;
                                s_d.oe   = 1'b1;
                                s_d.kind = K_DAT;
                                s_d.st   = ST_ACK;
                            end
                            default: begin
                                we       = 1'b1;
                                s_d.oe   = 1'b1;
                                s_d.st   = ST_ACK;
                                if (mode) s_d.kind = K_REG;
                                else      s_d.ptr  = s_q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        s_d.cnt = '0;
                        if (s_q.rw) begin
                            s_d.sh = rdata;
                            s_d.oe = ~rdata[DATA_W-1];
                            s_d.st = ST_TX;
                        end else begin
                            s_d.oe = 1'b0;
                            s_d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (s_q.cnt == CNT_W'(DATA_W - 1)) begin
                            s_d.oe = 1'b0;
                            s_d.st = ST_MACK;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                            s_d.sh  = s_q.sh << 1;
                            s_d.oe  = ~s_q.sh[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            s_d.ptr = s_q.ptr + 1'b1;
                            s_d.st  = ST_TXLOAD;
                        end else begin
                            s_d.st = ST_IDLE;
                        end
                    end
                end
                ST_TXLOAD: begin
                    if (scl_fall) begin
                        s_d.sh  = rdata;
                        s_d.oe  = ~rdata[DATA_W-1];
                        s_d.cnt = '0;
                        s_d.st  = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.kind <= K_SLV;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe = s_q.oe;
    assign raddr  = s_q.ptr;
endmodule

// File: rtl/i2c_regif_slave.sv
module i2c_regif_slave #(
    parameter int NUM_REGS    = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PIN_W       = 2,
    parameter int BASE_RST    = 'h4A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [PIN_W-1:0] addr_sel
);
    localparam int SA_W = DATA_W - 1;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic reg_we, wr_mode;
    logic [DATA_W-1:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;
    logic [SA_W-1:0]   base_addr;

    i2c_line_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .BASE_RST (BASE_RST)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .raddr (reg_raddr),
        .rdata (reg_rdata),
        .base  (base_addr),
        .mode  (wr_mode)
    );

    i2c_proto_fsm #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .base_hi   (base_addr[SA_W-1:PIN_W]),
        .pins      (addr_sel),
        .mode      (wr_mode),
        .rdata     (reg_rdata),
        .sda_oe    (sda_oe),
        .we        (reg_we),
        .waddr     (reg_waddr),
        .wdata     (reg_wdata),
        .raddr     (reg_raddr)
    );
endmodule

// File: rtl/i2c_regif_checker.sv
module i2c_regif_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_waddr,
    input logic [DATA_W-2:0] base_addr,
    input logic              wr_mode
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R4
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R10
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10
    AST_WRITE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> scl_fall); // R4
    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R5
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_waddr == '0) |=> $stable(base_addr)); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_waddr == DATA_W'(1)) |=> $stable(wr_mode)); // R6
endmodule

bind i2c_regif_slave i2c_regif_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .base_addr (base_addr),
    .wr_mode   (wr_mode)
);

// File: tb/tb_i2c_regif_slave.sv
module tb_i2c_regif_slave;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] pins = 2'b10;
    logic sda_oe;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [16];

    assign sda_line = sda_m & ~sda_oe;
    always #2 clk = ~clk;

    i2c_regif_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .addr_sel (pins)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL [%s] act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        ack = (sda_line == 1'b0);
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = ~mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_rd(input int idx);
        return (idx < 16) ? model[idx] : 8'h00;
    endfunction

    task automatic model_wr(input int idx, input logic [7:0] d);
        if (idx == 0)      model[0] = d & 8'h7F;
        else if (idx == 1) model[1] = d & 8'h01;
        else if (idx < 16) model[idx] = d;
    endtask

    task automatic wr_one(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d);
        bit a;
        i2c_start();
        wr_byte({dev, 1'b0}, a); chk(a, "R4", a, 1);
        wr_byte(ra, a);          chk(a, "R4", a, 1);
        wr_byte(d, a);           chk(a, "R4", a, 1);
        i2c_stop();
        model_wr(ra, d);
    endtask

    task automatic rd_run(input logic [6:0] dev, input logic [7:0] first, input int n);
        bit a;
        logic [7:0] b;
        i2c_start();
        wr_byte({dev, 1'b0}, a); chk(a, "R7", a, 1);
        wr_byte(first, a);       chk(a, "R7", a, 1);
        i2c_start();
        wr_byte({dev, 1'b1}, a); chk(a, "R7", a, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(b, i != n - 1);
            chk(b == exp_rd(int'(first) + i), "R7/R8 read data", b, exp_rd(int'(first) + i));
        end
        wq(Q);
        chk(sda_oe == 1'b0, "R7 release after NAK", sda_oe, 0);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL [R1] watchdog expired act=%0d exp=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        logic [6:0] dev;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        model[0] = 8'h4A;

        wq(5); rst_n = 1'b1; wq(5);
        chk(sda_oe == 1'b0, "R1 reset pull-down", sda_oe, 0);
        i2c_start();
        wr_byte(8'h94, a); chk(a, "R1 reset address 0x4A", a, 1);
        i2c_stop();

        // R2 / R3: every pin code against every neighbouring address
        for (int p = 0; p < 4; p++) begin
            pins = 2'(p);
            wq(4);
            for (int c = 0; c < 4; c++) begin
                i2c_start();
                wr_byte({5'b10010, 2'(c), 1'b0}, a);
                chk(a == (c == p), "R2 address match", a, (c == p));
                if (c != p) begin
                    wr_byte(8'h02, a);
                    chk(!a, "R3 silent after mismatch", a, 0);
                end
                i2c_stop();
            end
        end

        // R5: page burst over locations 2..15
        pins = 2'b00;
        dev = 7'h48;
        i2c_start();
        wr_byte({dev, 1'b0}, a); chk(a, "R4", a, 1);
        wr_byte(8'h02, a);       chk(a, "R4", a, 1);
        for (int i = 2; i < 16; i++) begin
            wr_byte(8'(i * 37 + 5), a);
            chk(a, "R5 page data ack", a, 1);
            model_wr(i, 8'(i * 37 + 5));
        end
        i2c_stop();
        rd_run(dev, 8'h00, 18);

        // R8: unimplemented write ignored, reads zero
        wr_one(dev, 8'h14, 8'hEE);
        rd_run(dev, 8'h13, 3);

        // R6: repeat mode pairs
        wr_one(dev, 8'h01, 8'hFF);
        rd_run(dev, 8'h01, 1);
        i2c_start();
        wr_byte({dev, 1'b0}, a); chk(a, "R6", a, 1);
        wr_byte(8'h05, a); chk(a, "R6 pair ptr", a, 1);
        wr_byte(8'hA5, a); chk(a, "R6 pair data", a, 1);
        wr_byte(8'h09, a); chk(a, "R6 pair ptr", a, 1);
        wr_byte(8'h3C, a); chk(a, "R6 pair data", a, 1);
        wr_byte(8'h03, a); chk(a, "R6 pair ptr", a, 1);
        wr_byte(8'h77, a); chk(a, "R6 pair data", a, 1);
        wr_byte(8'h01, a); chk(a, "R6 pair ptr", a, 1);
        wr_byte(8'h00, a); chk(a, "R6 pair data", a, 1);
        i2c_stop();
        model_wr(5, 8'hA5); model_wr(9, 8'h3C); model_wr(3, 8'h77); model_wr(1, 8'h00);
        rd_run(dev, 8'h01, 10);

        // back in page mode: two consecutive bytes
        i2c_start();
        wr_byte({dev, 1'b0}, a); wr_byte(8'h0B, a);
        wr_byte(8'h11, a); wr_byte(8'h22, a);
        chk(a, "R5 page after mode clear", a, 1);
        i2c_stop();
        model_wr(11, 8'h11); model_wr(12, 8'h22);
        rd_run(dev, 8'h0B, 2);

        // R10: START in mid-byte, then address matching again
        i2c_start();
        wr_byte({dev, 1'b0}, a); wr_byte(8'h06, a);
        send_bits(8'h5A, 4);
        i2c_start();
        wr_byte({dev, 1'b1}, a); chk(a, "R10 re-match after START", a, 1);
        rd_byte(b, 1'b0);
        chk(b == model[6], "R10 START abort kept data", b, model[6]);
        i2c_stop();
        // R10: STOP in mid-byte
        i2c_start();
        wr_byte({dev, 1'b0}, a); wr_byte(8'h07, a);
        send_bits(8'hC3, 5);
        i2c_stop();
        rd_run(dev, 8'h07, 1);

        // R9: move the device by rewriting its base
        wr_one(dev, 8'h00, 8'h20);
        pins = 2'b11;
        wq(4);
        i2c_start();
        wr_byte(8'h96, a); chk(!a, "R9 old address rejected", a, 0);
        i2c_stop();
        i2c_start();
        wr_byte(8'h46, a); chk(a, "R9 new address 0x23", a, 1);
        i2c_stop();
        rd_run(7'h23, 8'h00, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule